// File: doc/BRIEF.md
# Divider Ratio Solver

This block works out the settings of a two-stage clock divider: a prescaler followed by a post-divider. A caller presents a parent clock rate, a wanted output rate and the index of the parent that feeds the path. After a start pulse the block computes the prescaler and post-divider ratios. Their product is the smallest that brings the output down to or below the wanted rate. The block then reports those ratios in encoded form, together with the output rate they produce.

The path can only divide, so a wanted rate above the parent rate is first lowered to the parent rate. The total division is the ceiling of parent over request. The total is shared between the two stages only for one designated parent index, and only by fixed bands. Every other parent drives the post-divider alone. One iterative restoring divider inside the block is used twice: once for the total ratio and once for the achieved rate. A result therefore takes a little over two divider passes.

Top module: `ratio_solver`

## Requirements
- R1: When parent_rate is nonzero and req_rate exceeds it, the solver uses parent_rate as the request; a request equal to or below the parent rate is used as given.
- R2: The total ratio T is ceil(parent_rate / request). When parent_sel is not 3, or T is 4 or less, the prescaler ratio is 1 and the post-divider ratio is T. Each code output carries its ratio minus one (pre_code = prescaler-1, post_code = post-divider-1).
- R3: When parent_sel is 3 and T is above 4, the split is as follows. For T below 32 the prescaler is T and the post-divider is 1. For T below 64 the prescaler is ceil(T/2) and the post-divider is 2. For T below 96 the prescaler is ceil(T/3) and the post-divider is 3. For larger T the prescaler is ceil(T/4) and the post-divider is 4.
- R4: A ratio beyond its field saturates: a prescaler above 32 becomes 32 (pre_code 31), and a post-divider above 4 becomes 4 (post_code 3).
- R5: A request of zero (after R1) selects the slowest setting: post-divider 4, with prescaler 32 when parent_sel is 3 and 1 otherwise.
- R6: A parent rate of zero with a nonzero request gives a total ratio of 1: both codes 0 and an achieved rate of 0.
- R7: achieved equals floor(floor(parent_rate / prescaler) / post-divider) for the chosen ratios, over the full 32-bit parent range.
- R8: After reset busy, done and all result outputs are 0. A start seen while busy is low raises busy on the next cycle. done is a single-cycle pulse, high only while busy is low, coinciding with the fall of busy. The result outputs change only in the cycle done is high.
- R9: A start pulse while busy is high is ignored: the running result is unaffected and no extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| parent_rate | input | 32 | Parent clock rate, unsigned |
| req_rate | input | 32 | Wanted output rate, unsigned |
| parent_sel | input | 2 | Index of the parent feeding the path |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: result outputs are valid |
| pre_code | output | 5 | Prescaler ratio minus one |
| post_code | output | 2 | Post-divider ratio minus one |
| achieved | output | 32 | Output rate produced by the chosen ratios |

## Verification
The bench builds the solver with its default parameters. These are 32-bit rates, a 5-bit prescaler field, a 2-bit post-divider field and split index 3. With them the band edges at 32, 64 and 96 and the prescaler saturation above 128 can be reached with small parent and request values. Full-width parent rates push both divider passes through every quotient bit. Random cases choose the request as a fraction of the parent, so that totals fall across all bands on every parent index.

// File: rtl/ratio_solver_pkg.sv
package ratio_solver_pkg;

    localparam int DEF_RATE_W    = 32;
    localparam int DEF_PRE_W     = 5;
    localparam int DEF_POST_W    = 2;
    localparam int DEF_SEL_W     = 2;
    localparam int DEF_SPLIT_IDX = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TOT_GO,
        ST_TOT_RUN,
        ST_SPLIT,
        ST_ACH_GO,
        ST_ACH_RUN
    } solver_state_e;

endpackage

// File: rtl/restoring_div.sv
module restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, dsr_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted, trial;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dsr_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= dividend;
                dsr_q <= divisor;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quot = quo_q;
    assign rem  = rem_q;

endmodule

// File: rtl/ratio_split.sv
module ratio_split #(
    parameter int RATE_W = 32,
    parameter int PRE_W  = 5,
    parameter int POST_W = 2
) (
    input  logic [RATE_W-1:0] total,
    input  logic              split_en,
    input  logic              zero_req,
    output logic [PRE_W:0]    pre_ratio,
    output logic [POST_W:0]   post_ratio
);
    localparam int PRE_MAX  = 1 << PRE_W;
    localparam int POST_MAX = 1 << POST_W;
    localparam int XW       = RATE_W + 1;

    logic [XW-1:0] t_ext;
    logic [XW-1:0] q;
    logic          found;

    always_comb begin
        t_ext      = (total == '0) ? XW'(1) : {1'b0, total};
        pre_ratio  = (PRE_W+1)'(1);
        post_ratio = (POST_W+1)'(1);
        found      = 1'b0;
        q          = '0;
        if (zero_req) begin
            post_ratio = (POST_W+1)'(POST_MAX);
            pre_ratio  = split_en ? (PRE_W+1)'(PRE_MAX) : (PRE_W+1)'(1);
        end else if (!split_en || t_ext <= XW'(POST_MAX)) begin
            post_ratio = (t_ext > XW'(POST_MAX)) ? (POST_W+1)'(POST_MAX)
                                                 : t_ext[POST_W:0];
        end else begin
            for (int k = 1; k <= POST_MAX; k++) begin
                if (!found && (t_ext < XW'(PRE_MAX * k) || k == POST_MAX)) begin
                    found      = 1'b1;
                    post_ratio = (POST_W+1)'(k);
                    q          = (t_ext + XW'(k - 1)) / XW'(k);
                    pre_ratio  = (q > XW'(PRE_MAX)) ? (PRE_W+1)'(PRE_MAX)
                                                    : q[PRE_W:0];
                end
            end
        end
    end

endmodule

// File: rtl/ratio_solver.sv
module ratio_solver
    import ratio_solver_pkg::*;
#(
    parameter int RATE_W    = DEF_RATE_W,
    parameter int PRE_W     = DEF_PRE_W,
    parameter int POST_W    = DEF_POST_W,
    parameter int SEL_W     = DEF_SEL_W,
    parameter int SPLIT_IDX = DEF_SPLIT_IDX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] parent_rate,
    input  logic [RATE_W-1:0] req_rate,
    input  logic [SEL_W-1:0]  parent_sel,
    output logic              busy,
    output logic              done,
    output logic [PRE_W-1:0]  pre_code,
    output logic [POST_W-1:0] post_code,
    output logic [RATE_W-1:0] achieved
);
    localparam int PW = PRE_W + POST_W + 2;

    solver_state_e     state_q;
    logic [RATE_W-1:0] par_q, req_q, total_q;
    logic              split_q, zero_q;
    logic [PRE_W:0]    pre_q, pre_c;
    logic [POST_W:0]   post_q, post_c;
    logic [RATE_W-1:0] req_clamped;
    logic [PW-1:0]     prod;
    logic              dv_start, dv_done;
    logic [RATE_W-1:0] dv_divisor, dv_quot, dv_rem;

    always_comb begin
        req_clamped = (parent_rate != '0 && req_rate > parent_rate) ? parent_rate : req_rate;
        prod        = PW'(pre_q) * PW'(post_q);
        dv_start    = (state_q == ST_TOT_GO) || (state_q == ST_ACH_GO);
        dv_divisor  = (state_q == ST_TOT_GO) ? req_q : RATE_W'(prod);
    end

    restoring_div #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (dv_start),
        .dividend (par_q),
        .divisor  (dv_divisor),
        .done     (dv_done),
        .quot     (dv_quot),
        .rem      (dv_rem)
    );

    ratio_split #(.RATE_W(RATE_W), .PRE_W(PRE_W), .POST_W(POST_W)) u_split (
        .total      (total_q),
        .split_en   (split_q),
        .zero_req   (zero_q),
        .pre_ratio  (pre_c),
        .post_ratio (post_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            par_q     <= '0;
            req_q     <= '0;
            total_q   <= '0;
            split_q   <= 1'b0;
            zero_q    <= 1'b0;
            pre_q     <= '0;
            post_q    <= '0;
            done      <= 1'b0;
            pre_code  <= '0;
            post_code <= '0;
            achieved  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        par_q   <= parent_rate;
                        req_q   <= req_clamped;
                        split_q <= (parent_sel == SEL_W'(SPLIT_IDX));
                        zero_q  <= (req_clamped == '0);
                        total_q <= '0;
                        state_q <= (req_clamped == '0) ? ST_SPLIT : ST_TOT_GO;
                    end
                end
                ST_TOT_GO:  state_q <= ST_TOT_RUN;
                ST_TOT_RUN: begin
                    if (dv_done) begin
                        total_q <= dv_quot + RATE_W'(dv_rem != '0);
                        state_q <= ST_SPLIT;
                    end
                end
                ST_SPLIT: begin
                    pre_q   <= pre_c;
                    post_q  <= post_c;
                    state_q <= ST_ACH_GO;
                end
                ST_ACH_GO:  state_q <= ST_ACH_RUN;
                ST_ACH_RUN: begin
                    if (dv_done) begin
                        achieved  <= dv_quot;
                        pre_code  <= PRE_W'(pre_q - (PRE_W+1)'(1));
                        post_code <= POST_W'(post_q - (POST_W+1)'(1));
                        done      <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/ratio_solver_chk.sv
module ratio_solver_chk #(
    parameter int RATE_W = 32,
    parameter int PRE_W  = 5,
    parameter int POST_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [PRE_W-1:0]  pre_code,
    input logic [POST_W-1:0] post_code,
    input logic [RATE_W-1:0] achieved
);
    p_start_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_fall_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(achieved) && $stable(pre_code) && $stable(post_code)));

    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> (busy || done));

endmodule

bind ratio_solver ratio_solver_chk #(
    .RATE_W (RATE_W),
    .PRE_W  (PRE_W),
    .POST_W (POST_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pre_code  (pre_code),
    .post_code (post_code),
    .achieved  (achieved)
);

// File: tb/ratio_solver_tb.sv
module ratio_solver_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] parent_rate = '0;
    logic [31:0] req_rate = '0;
    logic [1:0]  parent_sel = '0;
    logic        busy, done;
    logic [4:0]  pre_code;
    logic [1:0]  post_code;
    logic [31:0] achieved;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    ratio_solver u_dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .parent_rate (parent_rate),
        .req_rate    (req_rate),
        .parent_sel  (parent_sel),
        .busy        (busy),
        .done        (done),
        .pre_code    (pre_code),
        .post_code   (post_code),
        .achieved    (achieved)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    function automatic void model(input longint p, input longint r, input int sel,
                                  output longint pre, output longint post,
                                  output longint ach);
        longint tot;
        if (p != 0 && r > p) r = p;
        if (r == 0) begin
            post = 4;
            pre  = (sel == 3) ? 32 : 1;
        end else begin
            tot = (p + r - 1) / r;
            if (tot == 0) tot = 1;
            if (sel != 3 || tot <= 4) begin
                pre  = 1;
                post = (tot > 4) ? 4 : tot;
            end else if (tot < 32) begin
                pre = tot;             post = 1;
            end else if (tot < 64) begin
                pre = (tot + 1) / 2;   post = 2;
            end else if (tot < 96) begin
                pre = (tot + 2) / 3;   post = 3;
            end else begin
                pre = (tot + 3) / 4;   post = 4;
                if (pre > 32) pre = 32;
            end
        end
        ach = p / pre / post;
    endfunction

    task automatic wait_done(input string tag);
        int w = 0;
        while (!done && w < 1000) begin
            @(negedge clk);
            w++;
        end
        if (!done) check({tag, " done timeout"}, 0, 1);
    endtask

    task automatic launch(input longint p, input longint r, input int sel);
        @(negedge clk);
        parent_rate = p[31:0];
        req_rate    = r[31:0];
        parent_sel  = sel[1:0];
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input string tag, input longint p, input longint r, input int sel);
        longint ep, eq, ea;
        model(p, r, sel, ep, eq, ea);
        launch(p, r, sel);
        check({tag, " busy after start (R8)"}, busy, 1);
        wait_done(tag);
        check({tag, " pre_code"}, pre_code, ep - 1);
        check({tag, " post_code"}, post_code, eq - 1);
        check({tag, " achieved"}, achieved, ea);
    endtask

    initial begin
        longint p, r;
        int sel, mode, dones;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check("R8 reset busy", busy, 0);
        check("R8 reset done", done, 0);
        check("R8 reset pre_code", pre_code, 0);
        check("R8 reset post_code", post_code, 0);
        check("R8 reset achieved", achieved, 0);

        run("R2 total 4 sel0", 1000, 300, 0);
        run("R2 total 2 sel3", 100, 50, 3);
        run("R1 clamp above parent", 100, 500, 1);
        run("R1 request equal parent", 777, 777, 3);
        run("R3 total 5", 500, 100, 3);
        run("R3 total 31", 3100, 100, 3);
        run("R3 total 32", 3200, 100, 3);
        run("R3 total 63", 6300, 100, 3);
        run("R3 total 64", 6400, 100, 3);
        run("R3 total 95", 9500, 100, 3);
        run("R3 total 96", 9600, 100, 3);
        run("R4 prescaler saturates", 12900, 100, 3);
        run("R4 post saturates sel2", 1000, 10, 2);
        run("R5 zero request sel3", 5000, 0, 3);
        run("R5 zero request sel0", 5000, 0, 0);
        run("R6 zero parent", 0, 77, 3);
        run("R7 full width parent", 64'hFFFF_FFFF, 7, 1);
        run("R7 full width split", 64'hFFFF_FFFF, 64'h0100_0000, 3);

        // R9: start during busy is ignored
        begin
            longint ep, eq, ea;
            model(6400, 100, 3, ep, eq, ea);
            launch(6400, 100, 3);
            repeat (5) @(negedge clk);
            parent_rate = 32'd10;
            req_rate    = 32'd1;
            parent_sel  = 2'd0;
            start       = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R9 busy kept", busy, 1);
            wait_done("R9");
            check("R9 pre_code", pre_code, ep - 1);
            check("R9 post_code", post_code, eq - 1);
            check("R9 achieved", achieved, ea);
            dones = 0;
            repeat (120) begin
                @(negedge clk);
                if (done || busy) dones++;
            end
            check("R9 no extra run", dones, 0);
        end

        for (int i = 0; i < 300; i++) begin
            p    = longint'($urandom);
            mode = int'($urandom % 4);
            sel  = int'($urandom % 4);
            case (mode)
                0: r = p / (longint'($urandom % 200) + 1);
                1: r = longint'($urandom % 1000);
                2: r = longint'($urandom);
                default: begin
                    p = longint'($urandom % 20000);
                    r = longint'($urandom % 300);
                end
            endcase
            run("R7 random", p, r, sel);
        end

        finish_run();
    end

endmodule